// File: doc/BRIEF.md
# Dual-Mode System Bus Arbiter

This block decides which of eight bus masters owns the shared system bus. The masters are an external bus master, an accelerator, two general-purpose DMA channels, two network DMA channels, a USB host DMA and the CPU core. A configuration bit selects one of two schemes. The first is a fixed ranking. The second rotates ownership among seven of the masters, while the external master still comes first. One grant line per master comes out as a registered, one-hot vector.

In the fixed scheme the CPU can be raised in rank while it handles an interrupt. When the boost enable bit is set, a pending interrupt sets a sticky "boost active" flag. While the enable bit and the flag are both high, the CPU ranks just below the external master. Software ends the boost by writing 0 to the flag, normally at the end of its interrupt routine. Writing 1 to the flag leaves it as it is. The rotating scheme ignores both the enable bit and the flag.

Once granted, a master keeps the bus until it lowers its request or pulses transfer-done. The grant then drops for one cycle, and the next arbitration takes place in the following cycle.

Top module: `sys_bus_arb`

## Requirements
- R1: After a synchronous active-low reset, no grant is active, the fixed scheme is selected (mode 0), the boost enable and boost active flags read 0, and the rotation pointer points at master 1.
- R2: Master indices are 0 external, 1 accelerator, 2 DMA0, 3 DMA1, 4 network DMA0, 5 network DMA1, 6 USB host, 7 CPU. In the fixed scheme (mode 0) with no boost, the lowest requesting index wins.
- R3: From idle, a grant appears on the clock edge after the request is sampled. A grant is held while its owner requests and transfer-done is low. When the owner drops its request or transfer-done is high, the grant clears on the next edge and stays clear for that cycle.
- R4: At most one grant is active at any time, and a new grant goes only to a master that was requesting when it was decided.
- R5: When the boost enable reads 1 and the interrupt-pending input is high, the boost active flag reads 1 after the next edge. With the enable at 0 the flag does not set.
- R6: A configuration write with the active-flag data bit at 0 clears the flag. A write with that bit at 1 leaves the flag unchanged. A hardware set in the same cycle takes precedence over a clear.
- R7: In the fixed scheme, while boost enable and boost active both read 1, master 7 ranks second, after master 0. Masters 1 to 6 keep their order below it.
- R8: In the rotating scheme (mode 1), master 0 wins whenever it requests at arbitration time.
- R9: In the rotating scheme, masters 1 to 7 are searched in cyclic order starting at the pointer. Each grant to master k in 1..7 moves the pointer to the master after k (7 wraps to 1). A grant to master 0 leaves the pointer unchanged.
- R10: In the rotating scheme, the boost enable and boost active flags have no effect on which master wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Request lines, bit index = master index |
| xfer_done_i | input | 1 | Current owner has finished its transfer |
| irq_pend_i | input | 1 | Interrupt pending towards the CPU |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_wr_i | input | 1 | Write data: scheme (0 fixed, 1 rotating) |
| cfg_boost_en_wr_i | input | 1 | Write data: boost enable |
| cfg_boost_act_wr_i | input | 1 | Write data: 0 clears boost active, 1 keeps it |
| gnt_o | output | 8 | One-hot registered grants |
| cfg_mode_o | output | 1 | Current scheme |
| cfg_boost_en_o | output | 1 | Current boost enable |
| cfg_boost_act_o | output | 1 | Current boost active flag |

## Verification
Every result lands exactly one edge after its cause. A grant follows one edge after the request was sampled while idle. A release follows one edge after the owner's request drops or transfer-done rises. Flag and mode changes follow one edge after the write strobe or the interrupt. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares grants and configuration outputs at the next falling edge, so each comparison falls in the cycle the result is due. Fixed and boosted ranking are swept over all 256 request patterns, and the rotating scheme is run against pseudo-random request and transfer-done streams.

// File: rtl/arb_pkg.sv
// Package: shared scheme encoding for the system bus arbiter.
// Assumes master 0 is always the external master and the highest index is the CPU.
package arb_pkg;
    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_mode_e;

    localparam int EXT_MASTER = 0;
endpackage

// File: rtl/arb_cfg_regs.sv
// Configuration registers: scheme bit, boost enable and the sticky boost active flag.
// Assumes one write strobe loads mode and enable together. The active flag
// data bit only ever clears, and a hardware set wins over a clear.
module arb_cfg_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pend_i,
    input  logic we_i,
    input  logic mode_wr_i,
    input  logic boost_en_wr_i,
    input  logic boost_act_wr_i,
    output logic mode_o,
    output logic boost_en_o,
    output logic boost_act_o
);
    logic hw_set;
    logic sw_clr;

    // Detect the hardware set and the software clear conditions.
    always_comb begin
        hw_set = boost_en_o && irq_pend_i;
        sw_clr = we_i && !boost_act_wr_i;
    end

    // Load the mode and enable bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o     <= arb_pkg::ARB_FIXED;
            boost_en_o <= 1'b0;
        end else if (we_i) begin
            mode_o     <= mode_wr_i;
            boost_en_o <= boost_en_wr_i;
        end
    end

    // Sticky boost flag: set by an interrupt, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            boost_act_o <= 1'b0;
        else if (hw_set)
            boost_act_o <= 1'b1;
        else if (sw_clr)
            boost_act_o <= 1'b0;
    end

    // R5
    boost_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_en_o && irq_pend_i) |=> boost_act_o);

    // R6
    clear_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !boost_act_wr_i && !(boost_en_o && irq_pend_i)) |=> !boost_act_o);

    // R6
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!boost_act_o && !(boost_en_o && irq_pend_i)) |=> !boost_act_o);
endmodule

// File: rtl/arb_pick.sv
// Winner selection: combinational choice of the next owner from the request vector.
// Assumes index 0 is the external master, which beats everything in both schemes.
// Fixed: lowest index wins, except that boost lifts the top index to second place.
// Rotating: indices 1..N-1 are searched cyclically from the pointer offset.
module arb_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int PW = $clog2(N - 1)
) (
    input  logic [N-1:0]  req_i,
    input  logic          mode_rot_i,
    input  logic          boost_i,
    input  logic [PW-1:0] ptr_i,
    output logic          win_valid_o,
    output logic [IW-1:0] win_idx_o
);
    localparam int GRP = N - 1;

    // Pick the winner for the active scheme.
    always_comb begin
        int w;
        int o;
        w = -1;
        o = 0;
        if (req_i[arb_pkg::EXT_MASTER]) begin
            w = arb_pkg::EXT_MASTER;
        end else if (mode_rot_i) begin
            for (int k = 0; k < GRP; k++) begin
                o = int'(ptr_i) + k;
                if (o >= GRP) o = o - GRP;
                if (w < 0 && req_i[o + 1]) w = o + 1;
            end
        end else begin
            if (boost_i && req_i[N-1]) w = N - 1;
            for (int i = 1; i < N; i++) begin
                if (w < 0 && req_i[i]) w = i;
            end
        end
        win_valid_o = (w >= 0);
        win_idx_o   = (w >= 0) ? IW'(w) : '0;
    end
endmodule

// File: rtl/arb_grant_ctrl.sv
// Grant ownership and rotation pointer.
// Assumes the winner inputs are valid every cycle. A new grant is only issued
// from idle, so every release costs one idle cycle before the next owner.
module arb_grant_ctrl #(
    parameter int N  = 8,
    parameter int IW = $clog2(N),
    parameter int PW = $clog2(N - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          xfer_done_i,
    input  logic          win_valid_i,
    input  logic [IW-1:0] win_idx_i,
    output logic [N-1:0]  gnt_o,
    output logic [PW-1:0] ptr_o
);
    localparam int GRP = N - 1;

    logic [IW-1:0] owner_q;
    logic          busy;
    logic          release_now;

    // Decide whether the current owner keeps the bus.
    always_comb begin
        busy        = |gnt_o;
        release_now = busy && (!req_i[owner_q] || xfer_done_i);
    end

    // Hold, release or issue a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_o   <= '0;
            owner_q <= '0;
        end else if (release_now) begin
            gnt_o <= '0;
        end else if (!busy && win_valid_i) begin
            gnt_o   <= N'(1) << win_idx_i;
            owner_q <= win_idx_i;
        end
    end

    // Move the pointer past each granted member of the rotating group.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_o <= '0;
        else if (!busy && win_valid_i && win_idx_i != '0)
            ptr_o <= (int'(win_idx_i) >= GRP) ? '0 : PW'(win_idx_i);
    end

    // R4
    onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R4
    grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |=> ((gnt_o & $past(req_i)) == gnt_o));

    // R3
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && ((gnt_o & req_i) != '0) && !xfer_done_i) |=> $stable(gnt_o));

    // R3
    release_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && (((gnt_o & req_i) == '0) || xfer_done_i)) |=> (gnt_o == '0));

    // R9
    ext_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o == '0) && req_i[0]) |=> $stable(ptr_o));
endmodule

// File: rtl/sys_bus_arb.sv
// Top: dual-scheme system bus arbiter for N masters.
// Assumes index 0 is the external master and index N-1 is the CPU core.
// Grants are registered, and configuration is written through a simple strobe.
module sys_bus_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         xfer_done_i,
    input  logic         irq_pend_i,
    input  logic         cfg_we_i,
    input  logic         cfg_mode_wr_i,
    input  logic         cfg_boost_en_wr_i,
    input  logic         cfg_boost_act_wr_i,
    output logic [N-1:0] gnt_o,
    output logic         cfg_mode_o,
    output logic         cfg_boost_en_o,
    output logic         cfg_boost_act_o
);
    localparam int IW = $clog2(N);
    localparam int PW = $clog2(N - 1);

    logic          boost_on;
    logic          win_valid;
    logic [IW-1:0] win_idx;
    logic [PW-1:0] rr_ptr;

    arb_cfg_regs u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_pend_i     (irq_pend_i),
        .we_i           (cfg_we_i),
        .mode_wr_i      (cfg_mode_wr_i),
        .boost_en_wr_i  (cfg_boost_en_wr_i),
        .boost_act_wr_i (cfg_boost_act_wr_i),
        .mode_o         (cfg_mode_o),
        .boost_en_o     (cfg_boost_en_o),
        .boost_act_o    (cfg_boost_act_o)
    );

    // Boost applies only in the fixed scheme with both flags set.
    always_comb begin
        boost_on = (cfg_mode_o == arb_pkg::ARB_FIXED) && cfg_boost_en_o && cfg_boost_act_o;
    end

    arb_pick #(.N(N), .IW(IW), .PW(PW)) u_pick (
        .req_i       (req_i),
        .mode_rot_i  (cfg_mode_o),
        .boost_i     (boost_on),
        .ptr_i       (rr_ptr),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx)
    );

    arb_grant_ctrl #(.N(N), .IW(IW), .PW(PW)) u_gnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .xfer_done_i (xfer_done_i),
        .win_valid_i (win_valid),
        .win_idx_i   (win_idx),
        .gnt_o       (gnt_o),
        .ptr_o       (rr_ptr)
    );

    // R8
    ext_first_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_o && (gnt_o == '0) && req_i[0]) |=> gnt_o[0]);

    // R7
    boost_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_on && (gnt_o == '0) && !req_i[0] && req_i[N-1]) |=> gnt_o[N-1]);

    // R2
    ext_first_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode_o && (gnt_o == '0) && req_i[0]) |=> gnt_o[0]);
endmodule

// File: tb/sys_bus_arb_tb.sv
`timescale 1ns/1ps
module sys_bus_arb_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         done = 1'b0;
    logic         irq = 1'b0;
    logic         we = 1'b0;
    logic         wmode = 1'b0;
    logic         wen = 1'b0;
    logic         wact = 1'b1;
    logic [N-1:0] gnt;
    logic         mode_o, en_o, act_o;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_gnt = '0;
    int           m_ptr = 0;
    logic         m_mode = 1'b0, m_en = 1'b0, m_act = 1'b0;
    logic [15:0]  lfsr = 16'hACE1;

    always #4 clk = ~clk;

    sys_bus_arb #(.N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .xfer_done_i(done), .irq_pend_i(irq),
        .cfg_we_i(we), .cfg_mode_wr_i(wmode), .cfg_boost_en_wr_i(wen),
        .cfg_boost_act_wr_i(wact), .gnt_o(gnt), .cfg_mode_o(mode_o),
        .cfg_boost_en_o(en_o), .cfg_boost_act_o(act_o)
    );

    // Rank in the fixed scheme: smaller is stronger.
    function automatic int fixed_rank(int i, logic boost);
        if (i == 0) return 0;
        if (boost) return (i == N - 1) ? 1 : i + 1;
        return i;
    endfunction

    // Advance the reference state by one rising edge.
    task automatic model_update();
        logic [N-1:0] ng;
        int np, w, best, r;
        logic boost;
        ng = m_gnt; np = m_ptr;
        if (!rst_n) begin
            m_gnt = '0; m_ptr = 0; m_mode = 0; m_en = 0; m_act = 0;
            return;
        end
        if (m_gnt != '0) begin
            if (((m_gnt & req) == '0) || done) ng = '0;
        end else begin
            w = -1; best = 1000;
            boost = !m_mode && m_en && m_act;
            for (int i = 0; i < N; i++) begin
                if (req[i]) begin
                    if (i == 0) r = -1;
                    else if (m_mode) r = (i - 1 - m_ptr + (N - 1)) % (N - 1);
                    else r = fixed_rank(i, boost);
                    if (r < best) begin best = r; w = i; end
                end
            end
            if (w >= 0) begin
                ng = '0; ng[w] = 1'b1;
                if (w > 0) np = w % (N - 1);
            end
        end
        if (m_en && irq) m_act = 1'b1;
        else if (we && !wact) m_act = 1'b0;
        if (we) begin m_mode = wmode; m_en = wen; end
        m_gnt = ng; m_ptr = np;
    endtask

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One clock: model at the rising edge, compare at the falling edge.
    task automatic step(string tag);
        @(posedge clk);
        #1 model_update();
        @(negedge clk);
        check(tag, gnt, m_gnt, "grant");
        check(tag, {5'b0, mode_o, en_o, act_o}, {5'b0, m_mode, m_en, m_act}, "cfg");
    endtask

    task automatic cfg_write(logic md, logic en, logic ac, string tag);
        we = 1; wmode = md; wen = en; wact = ac;
        step(tag);
        we = 0; wact = 1;
    endtask

    task automatic sweep(string tag);
        for (int p = 0; p < 256; p++) begin
            req = p[N-1:0];
            step(tag);
            req = '0;
            step("R3");
            step(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1'b1;
        // R1: reset state, grants idle
        check("R1", gnt, '0, "reset grant");
        check("R1", {5'b0, mode_o, en_o, act_o}, '0, "reset cfg");
        // R2: fixed ranking, all patterns
        sweep("R2");
        // R3: hold against a stronger request, release by transfer-done
        req = 8'h80; step("R3");
        req = 8'hFF; step("R3"); step("R3");
        done = 1; step("R3");
        done = 0; step("R4");
        req = '0; step("R3"); step("R3");
        // R5: no set while disabled
        irq = 1; step("R5"); irq = 0;
        cfg_write(0, 1, 1, "R5");
        irq = 1; step("R5"); irq = 0;
        // R6: write 1 keeps, clear with set pending keeps, write 0 clears
        cfg_write(0, 1, 1, "R6");
        irq = 1; cfg_write(0, 1, 0, "R6"); irq = 0;
        cfg_write(0, 1, 0, "R6");
        // R7: boosted fixed ranking
        irq = 1; step("R7"); irq = 0;
        sweep("R7");
        // R8 / R9 / R10: rotating scheme with boost flags still set
        cfg_write(1, 1, 1, "R10");
        req = 8'hFE;
        for (int i = 0; i < 40; i++) begin
            done = i[0];
            step("R9");
        end
        done = 0; req = '0; step("R9"); step("R9");
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req  = lfsr[7:0] & (lfsr[8] ? 8'hFF : 8'hFE);
            done = lfsr[11] & lfsr[9];
            irq  = lfsr[14] & lfsr[2];
            step(lfsr[0] ? "R8" : "R10");
        end
        irq = 0; done = 0; req = '0;
        cfg_write(1, 0, 0, "R10");
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req  = lfsr[7:0];
            done = lfsr[12];
            step("R9");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule